// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written over a one-cycle strobe into asynchronous serial frames on a single output line. A one-character holding register sits ahead of the frame shifter. A new byte can therefore be accepted while the previous one is still going out, and two status outputs report whether each of the two stages is empty.

The line is paced by a transmit tick, a one-cycle enable pulse that the surrounding logic supplies at 1, 16 or 64 times the baud rate. Format inputs set the character length, the parity mode, the stop length and the tick multiplier. The format is captured when a byte enters the shifter, so it may change between frames. A transmitter enable input gates only the move from the holding register into the shifter.

Top module: `async_char_tx`

## Requirements
- R1: After reset, `txd`, `hold_empty` and `shift_empty` are all 1. Whenever the shifter is empty, `txd` is 1.
- R2: A frame is a start bit at 0, then the character bits least significant first, then the parity bit if enabled, then stop time at 1. The first tick after the byte enters the shifter belongs to the start bit.
- R3: `fmt_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 character bits. Bits of `wr_data` above the selected length are not sent.
- R4: With `fmt_par_en`=1, a parity bit follows the character. With `fmt_par_odd`=0 the character bits plus the parity bit hold an even count of ones, and with `fmt_par_odd`=1 they hold an odd count.
- R5: The stop time in ticks is T for `fmt_stop`=0, T plus T/2 for `fmt_stop`=1 (2 ticks when T is 1), and 2T for `fmt_stop`=2 or 3. T is the ticks per bit.
- R6: `fmt_mult` values 0, 1, 2 and 3 set T to 1, 16, 64 and 64 ticks. Every start, character and parity bit lasts exactly T ticks.
- R7: `hold_empty` is 1 while the holding register is empty. It is 0 from the clock edge that accepts a write.
- R8: A byte moves from the holding register to the shifter on the clock edge after it is accepted, if the shifter is idle and `tx_en` is 1. On that edge `shift_empty` falls and `hold_empty` rises. `shift_empty` rises again after the last stop tick when no byte follows.
- R9: While `tx_en` is 0, no byte enters the shifter. A held byte waits and `txd` stays 1. A frame already started is completed.
- R10: A write while `hold_empty` is 0 is ignored: the held byte is kept and no extra frame is sent.
- R11: If a byte is held when the final stop tick of a frame ends, the next start bit begins on that same edge. No idle tick separates the frames, and `shift_empty` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Transmit tick enable, 1/16/64 per bit time |
| tx_en | input | 1 | Allow transfer from holding register to shifter |
| fmt_len | input | 2 | Character length select (5 to 8 bits) |
| fmt_par_en | input | 1 | Append a parity bit |
| fmt_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| fmt_stop | input | 2 | Stop length select (1, 1.5, 2 bits) |
| fmt_mult | input | 2 | Ticks per bit select (1, 16, 64) |
| wr_stb | input | 1 | Write strobe for a new character |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line, idle high |
| hold_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | Shifter idle, line not framing |

## Verification
Two events can fall on the same clock edge: the final stop tick of one frame ends, and the next byte moves out of the holding register. The bench provokes this by writing a second byte as soon as the first one enters the shifter. The second frame's start is then already waiting when the first frame's stop time runs out. The scoreboard monitor judges the pair by requiring that the tick sample right after the last stop sample is a start bit. An assertion requires that `shift_empty` stays low and `txd` goes low on the edge after the coincidence.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int unsigned CHAR_W = 8;
  localparam int unsigned TICK_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_STOP = 2'd2
  } tx_phase_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
    logic [1:0] mult;
  } tx_fmt_t;

  // number of character bits for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] len);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) m[i] = (i < int'(char_bits(len)));
    return m;
  endfunction

  // parity bit that completes an even (odd=0) or odd (odd=1) ones count
  function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                     input logic [1:0] len,
                                     input logic odd);
    return (^(d & char_mask(len))) ^ odd;
  endfunction

  function automatic logic [TICK_W-1:0] bit_ticks(input logic [1:0] mult);
    case (mult)
      2'd0:    return TICK_W'(1);
      2'd1:    return TICK_W'(16);
      default: return TICK_W'(64);
    endcase
  endfunction

  function automatic logic [TICK_W-1:0] stop_ticks(input logic [1:0] stop,
                                                   input logic [1:0] mult);
    logic [TICK_W-1:0] t;
    logic [TICK_W-1:0] h;
    t = bit_ticks(mult);
    h = t >> 1;
    if (h == '0) h = TICK_W'(1);
    case (stop)
      2'd0:    return t;
      2'd1:    return t + h;
      default: return t << 1;
    endcase
  endfunction

endpackage

// File: rtl/async_tx_holdbuf.sv
module async_tx_holdbuf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] q
);

  logic accept;
  assign accept = wr_stb && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (accept) begin
      full <= 1'b1;
      q    <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/async_tx_bit_timer.sv
module async_tx_bit_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign expire = tick && (cnt == limit - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (expire) cnt <= '0;
    else if (tick)   cnt <= cnt + ONE;
  end

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
  import async_tx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_char,
  input  tx_fmt_t           fmt,
  input  logic              expire,
  output logic [CNT_W-1:0]  limit,
  output logic              busy,
  output logic              frame_end,
  output logic              txd
);

  localparam int unsigned FR_W   = CHAR_W + 2;
  localparam int unsigned LEFT_W = $clog2(FR_W + 1);
  localparam logic [LEFT_W-1:0] LEFT_ONE = LEFT_W'(1);

  tx_phase_e         phase;
  logic [FR_W-1:0]   sr;
  logic [LEFT_W-1:0] left;
  logic [CNT_W-1:0]  tpb_q;
  logic [CNT_W-1:0]  stop_q;

  logic [FR_W-1:0]   img;
  logic [LEFT_W-1:0] img_len;
  logic [3:0]        nb;
  logic [3:0]        pidx;
  logic              pbit;

  always_comb begin
    nb   = char_bits(fmt.len);
    pidx = nb + 4'd1;
    pbit = parity_of(load_char, fmt.len, fmt.par_odd);
    img  = '1;
    img[0] = 1'b0;
    for (int k = 0; k < CHAR_W; k++) begin
      if (k < int'(nb)) img[k+1] = load_char[k];
    end
    if (fmt.par_en) img[pidx] = pbit;
    img_len = LEFT_W'(nb) + LEFT_ONE + LEFT_W'(fmt.par_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      sr     <= '1;
      left   <= '0;
      tpb_q  <= CNT_W'(1);
      stop_q <= CNT_W'(1);
    end else if (load) begin
      phase  <= PH_DATA;
      sr     <= img;
      left   <= img_len;
      tpb_q  <= CNT_W'(bit_ticks(fmt.mult));
      stop_q <= CNT_W'(stop_ticks(fmt.stop, fmt.mult));
    end else if (expire) begin
      case (phase)
        PH_DATA: begin
          sr   <= {1'b1, sr[FR_W-1:1]};
          left <= left - LEFT_ONE;
          if (left == LEFT_ONE) phase <= PH_STOP;
        end
        PH_STOP: phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign frame_end = (phase == PH_STOP) && expire;
  assign txd       = (phase == PH_DATA) ? sr[0] : 1'b1;
  assign limit     = (phase == PH_STOP) ? stop_q : tpb_q;

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import async_tx_pkg::*;
#(
  parameter int unsigned CNT_W = TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic [1:0]        fmt_len,
  input  logic              fmt_par_en,
  input  logic              fmt_par_odd,
  input  logic [1:0]        fmt_stop,
  input  logic [1:0]        fmt_mult,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty
);

  tx_fmt_t           fmt;
  logic              hold_full;
  logic [CHAR_W-1:0] hold_char;
  logic              busy;
  logic              frame_end_evt;
  logic              xfer_evt;
  logic              bit_expire;
  logic [CNT_W-1:0]  bit_limit;

  assign fmt = '{len: fmt_len, par_en: fmt_par_en, par_odd: fmt_par_odd,
                 stop: fmt_stop, mult: fmt_mult};

  // move the held byte when the shifter is idle or finishing this cycle
  assign xfer_evt = hold_full && tx_en && (!busy || frame_end_evt);

  async_tx_holdbuf #(.W(CHAR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .take    (xfer_evt),
    .full    (hold_full),
    .q       (hold_char)
  );

  async_tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (xfer_evt),
    .tick   (tick),
    .limit  (bit_limit),
    .expire (bit_expire)
  );

  async_tx_framer #(.CNT_W(CNT_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (xfer_evt),
    .load_char (hold_char),
    .fmt       (fmt),
    .expire    (bit_expire),
    .limit     (bit_limit),
    .busy      (busy),
    .frame_end (frame_end_evt),
    .txd       (txd)
  );

  assign hold_empty  = !hold_full;
  assign shift_empty = !busy;

endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty,
  input logic xfer_evt,
  input logic frame_end_evt
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !txd);

  // R7
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty && wr_stb) |=> !hold_empty);

  // R8
  xfer_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> (!shift_empty && hold_empty));

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && shift_empty) |=> shift_empty);

  // R10
  full_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && wr_stb && !xfer_evt) |=> !hold_empty);

  // R11
  chained_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_evt && xfer_evt) |=> (!shift_empty && !txd));

endmodule

bind async_char_tx async_char_tx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_en         (tx_en),
  .wr_stb        (wr_stb),
  .txd           (txd),
  .hold_empty    (hold_empty),
  .shift_empty   (shift_empty),
  .xfer_evt      (xfer_evt),
  .frame_end_evt (frame_end_evt)
);

// File: tb/tb_async_char_tx.sv
module tb_async_char_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tx_en = 1'b1;
  logic [1:0] fmt_len = 2'd3;
  logic       fmt_par_en = 1'b0;
  logic       fmt_par_odd = 1'b0;
  logic [1:0] fmt_stop = 2'd0;
  logic [1:0] fmt_mult = 2'd0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd;
  logic       hold_empty;
  logic       shift_empty;

  int nchk = 0;
  int nfail = 0;
  int tick_div = 1;
  int frames_sent = 0;
  int frames_seen = 0;
  bit mon_busy = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] data;
    int         nb;
    bit         pe;
    logic       pbit;
    int         tpb;
    int         stopt;
    bit         chained;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  async_char_tx dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .tx_en       (tx_en),
    .fmt_len     (fmt_len),
    .fmt_par_en  (fmt_par_en),
    .fmt_par_odd (fmt_par_odd),
    .fmt_stop    (fmt_stop),
    .fmt_mult    (fmt_mult),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // tick generator: one pulse every tick_div cycles
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1 >= tick_div) ? 0 : c + 1;
      tick = (c == 0);
    end
  end

  function automatic exp_t make_exp(input logic [7:0] d, input bit chained);
    exp_t e;
    int ones = 0;
    e.nb = 5 + int'(fmt_len);
    e.data = 8'h00;
    for (int i = 0; i < e.nb; i++) e.data[i] = d[i];
    for (int i = 0; i < 8; i++) ones += int'(e.data[i]);
    e.pe = fmt_par_en;
    e.pbit = logic'(ones % 2) ^ fmt_par_odd;
    e.tpb = (fmt_mult == 2'd0) ? 1 : (fmt_mult == 2'd1) ? 16 : 64;
    if (fmt_stop == 2'd0) e.stopt = e.tpb;
    else if (fmt_stop == 2'd1) e.stopt = e.tpb + ((e.tpb == 1) ? 1 : e.tpb / 2);
    else e.stopt = 2 * e.tpb;
    e.chained = chained;
    return e;
  endfunction

  // driver: waits for room, writes, pushes the expected frame
  task automatic send(input logic [7:0] d);
    bit chained;
    bit idle_go;
    do @(negedge clk); while (!hold_empty);
    chained = !shift_empty;
    idle_go = shift_empty && tx_en;
    sb.push_back(make_exp(d, chained));
    frames_sent++;
    wr_stb = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(hold_empty == 1'b0, "R7 hold_empty after write", int'(hold_empty), 0);
    if (idle_go) begin
      @(negedge clk);
      chk(shift_empty == 1'b0 && hold_empty == 1'b1, "R8 flags after transfer",
          int'({shift_empty, hold_empty}), 1);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin
      @(negedge clk);
      #3;
      n++;
    end while (!(sb.size() == 0 && !mon_busy && shift_empty && hold_empty) && n < 20000);
    chk(shift_empty && hold_empty && txd, "R8 idle after frames",
        int'({shift_empty, hold_empty, txd}), 7);
    chk(frames_seen == frames_sent, "R10 frame count", frames_seen, frames_sent);
  endtask

  task automatic get_sample(output logic v);
    do begin
      @(negedge clk);
      #2;
    end while (tick !== 1'b1);
    v = txd;
  endtask

  // monitor: reads the line once per tick and compares with the scoreboard
  initial begin
    logic v;
    logic s;
    bit pend = 1'b0;
    bit ok_w;
    bit ok_s;
    logic [7:0] word;
    logic pb;
    exp_t e;
    forever begin
      if (!pend) begin
        get_sample(v);
      end else begin
        v = 1'b0;
      end
      pend = 1'b0;
      if (v === 1'b0 && rst_n) begin
        mon_busy = 1'b1;
        if (sb.size() == 0) begin
          chk(1'b0, "R10 unexpected frame on line", 1, 0);
          do get_sample(v); while (v !== 1'b1);
        end else begin
          e = sb.pop_front();
          ok_w = 1'b1;
          for (int k = 1; k < e.tpb; k++) begin
            get_sample(s);
            if (s !== 1'b0) ok_w = 1'b0;
          end
          word = 8'h00;
          for (int b = 0; b < e.nb; b++) begin
            get_sample(v);
            word[b] = v;
            for (int k = 1; k < e.tpb; k++) begin
              get_sample(s);
              if (s !== v) ok_w = 1'b0;
            end
          end
          pb = 1'b0;
          if (e.pe) begin
            get_sample(pb);
            for (int k = 1; k < e.tpb; k++) begin
              get_sample(s);
              if (s !== pb) ok_w = 1'b0;
            end
          end
          ok_s = 1'b1;
          for (int k = 0; k < e.stopt; k++) begin
            get_sample(s);
            if (s !== 1'b1) ok_s = 1'b0;
          end
          frames_seen++;
          chk(word == e.data, "R2 R3 character bits", int'(word), int'(e.data));
          chk(ok_w, "R6 bit duration in ticks", int'(ok_w), 1);
          if (e.pe) chk(pb == e.pbit, "R4 parity bit", int'(pb), int'(e.pbit));
          chk(ok_s, "R5 stop time", int'(ok_s), 1);
          if (sb.size() > 0 && sb[0].chained) begin
            get_sample(v);
            chk(v === 1'b0, "R11 next start right after stop", int'(v), 0);
            if (v === 1'b0) pend = 1'b1;
          end
        end
        mon_busy = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R8 transmitter never went idle actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic set_fmt(input logic [1:0] len, input logic pe, input logic po,
                         input logic [1:0] st, input logic [1:0] mu, input int div);
    @(negedge clk);
    fmt_len = len;
    fmt_par_en = pe;
    fmt_par_odd = po;
    fmt_stop = st;
    fmt_mult = mu;
    tick_div = div;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
    chk(shift_empty == 1'b1, "R1 shift_empty after reset", int'(shift_empty), 1);

    // 8 bits, no parity, 1 stop, 1x, tick every cycle, chained burst (R11)
    set_fmt(2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 1);
    send(8'h47);
    send(8'hA5);
    send(8'h00);
    wait_idle();

    // 7 bits, no parity, 2 stop, 16x (R3 drops bit 7)
    set_fmt(2'd2, 1'b0, 1'b0, 2'd2, 2'd1, 2);
    send(8'hC9);
    send(8'h55);
    wait_idle();

    // 5 bits, even parity, 1.5 stop at 1x (2 ticks)
    set_fmt(2'd0, 1'b1, 1'b0, 2'd1, 2'd0, 3);
    send(8'h1B);
    send(8'hF3);
    wait_idle();

    // 6 bits, odd parity, 1 stop, 64x
    set_fmt(2'd1, 1'b1, 1'b1, 2'd0, 2'd2, 1);
    send(8'h2D);
    wait_idle();

    // 8 bits, odd parity, 1.5 stop, 16x
    set_fmt(2'd3, 1'b1, 1'b1, 2'd1, 2'd1, 1);
    send(8'h80);
    send(8'h7F);
    wait_idle();

    // 8 bits, even parity, 2 stop, 1x, tick every cycle
    set_fmt(2'd3, 1'b1, 1'b0, 2'd3, 2'd0, 1);
    send(8'hFF);
    send(8'h01);
    wait_idle();

    // R9 / R10: disabled transmitter holds the byte, a second write is dropped
    set_fmt(2'd3, 1'b0, 1'b0, 2'd0, 2'd1, 1);
    tx_en = 1'b0;
    send(8'h96);
    repeat (100) @(negedge clk);
    chk(shift_empty == 1'b1, "R9 no transfer while disabled", int'(shift_empty), 1);
    chk(txd == 1'b1, "R9 line idle while disabled", int'(txd), 1);
    chk(hold_empty == 1'b0, "R9 byte still held", int'(hold_empty), 0);
    wr_stb = 1'b1;
    wr_data = 8'h3C;
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
    chk(hold_empty == 1'b0, "R10 held byte kept after extra write", int'(hold_empty), 0);
    tx_en = 1'b1;
    wait_idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule